// File: doc/BRIEF.md
# Single-Error-Correcting, Double-Error-Detecting Word Controller

This block sits between a memory controller's request paths and its storage. Each word is 128 bits wide and is protected by a Hamming code of eight check bits plus one overall parity bit, which together detect and correct errors. These check bits live in a side array, and each word also carries a valid flag. On a write, the block computes the protection bits and passes data, byte mask, check bits and valid flag to the external arrays. On a read, it presents the address to the arrays. One cycle later it decodes the returned word and check bits, then delivers the data together with error flags and the syndrome.

The behaviour of a read depends on three things: who asked for it, whether checking is enabled, and whether the stored word is marked valid. Instruction fetches, both DMA paths and victim writebacks receive corrected data. Data-cache line fills see the error flags but receive the raw word. The enable input affects only reads. Writes always store protection, and any write that does not cover all sixteen bytes leaves the word marked invalid, with zero check bits.

Top module: `secded_word_ctl`

## Requirements
- R1: With checking enabled and the stored word valid, a single flipped bit anywhere in the data, the eight check bits or the overall parity bit raises err_single. The original data is returned for the classes fetch (0), internal DMA (2), DMA (3) and victim (4).
- R2: A write with all sixteen byte enables set drives mem_wvalid to 1 and mem_wchk to the word's protection bits, whether chk_en is 0 or 1. A later enabled read of that word can then correct a single flip.
- R3: A write with any byte enable clear drives mem_wvalid to 0 and mem_wchk to all zeros, whether chk_en is 0 or 1.
- R4: If chk_en was 0 in the cycle of the read request, the response returns the stored data unmodified, with err_single, err_double and syndrome all zero.
- R5: A read of class data-cache fill (1) reports err_single, err_double and syndrome as any other class would, but returns the stored data without correction.
- R6: A read of a word whose stored valid flag is 0 returns the stored data unmodified, with all flags and the syndrome zero.
- R7: Two flipped bits raise err_double, leave err_single low and return the stored data unmodified. err_single and err_double are never high together.
- R8: syndrome[8] is the overall parity mismatch and syndrome[7:0] is the Hamming syndrome. Check bit j sits at codeword position 2^j. Data bit i sits at the (i+1)-th position, counting from 1, that is not a power of two. A single flip at position p gives {1, p}. A flip of the overall parity bit, stored in mem_wchk[8], gives {1, 0}. Two flips give {0, p1 XOR p2}.
- R9: mem_re and mem_raddr follow rd_en and rd_addr in the same cycle. rsp_valid and its data, flags and syndrome appear in exactly the next cycle, once per request, and back-to-back requests are accepted. rsp_valid is 0 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| chk_en | input | 1 | Enables checking for reads requested this cycle |
| wr_en | input | 1 | Write request |
| wr_addr | input | 6 | Write word address |
| wr_data | input | 128 | Write data |
| wr_be | input | 16 | Write byte enables |
| rd_en | input | 1 | Read request |
| rd_addr | input | 6 | Read word address |
| rd_class | input | 3 | Requester: 0 fetch, 1 data-cache fill, 2 internal DMA, 3 DMA, 4 victim |
| mem_we | output | 1 | Array write strobe |
| mem_waddr | output | 6 | Array write address |
| mem_wdata | output | 128 | Array write data |
| mem_wbe | output | 16 | Array byte enables |
| mem_wchk | output | 9 | Side array check bits; bit 8 is overall parity |
| mem_wvalid | output | 1 | Side array valid flag |
| mem_re | output | 1 | Array read strobe |
| mem_raddr | output | 6 | Array read address |
| mem_rdata | input | 128 | Array read data, one cycle after mem_re |
| mem_rchk | input | 9 | Side array check bits, one cycle after mem_re |
| mem_rvalid | input | 1 | Side array valid flag, one cycle after mem_re |
| rsp_valid | output | 1 | Read response strobe |
| rsp_data | output | 128 | Read response data |
| err_single | output | 1 | Single-bit error seen |
| err_double | output | 1 | Uncorrectable error seen |
| syndrome | output | 9 | {parity mismatch, Hamming syndrome} |

## Verification
The write-side outputs mem_wchk and mem_wvalid are combinational from the request. The bench therefore samples them a short delay after driving a write and before the clock edge that commits it. A read response is due one cycle after the request. The bench stamps each expected item with the cycle number its request was accepted in plus one. The monitor pops items on the falling edge whenever rsp_valid is high and compares both the cycle stamp and the fields. At the end, the bench requires an empty queue, so a response that is missing, late or duplicated is reported.

// File: rtl/secded_ctl_pkg.sv
package secded_ctl_pkg;

   typedef enum logic [2:0] {
      RQ_FETCH  = 3'd0,
      RQ_FILL   = 3'd1,
      RQ_IDMA   = 3'd2,
      RQ_DMA    = 3'd3,
      RQ_VICTIM = 3'd4
   } req_class_e;

   // number of Hamming check bits needed to cover dw data bits
   function automatic int hamming_bits(input int dw);
      int r;
      r = 1;
      while ((1 << r) < dw + r + 1) r++;
      return r;
   endfunction

   // codeword position (1-based) of data bit idx: skip power-of-two slots
   function automatic int data_position(input int idx);
      int p;
      int n;
      p = 0;
      n = -1;
      while (n < idx) begin
         p++;
         if ((p & (p - 1)) != 0) n++;
      end
      return p;
   endfunction

endpackage

// File: rtl/secded_enc.sv
module secded_enc #(
   parameter int DATA_W = 128,
   parameter int CHK_W  = 8
) (
   input  logic [DATA_W-1:0] data,
   output logic [CHK_W-1:0]  hbits
);
   logic [CHK_W-1:0] term [DATA_W];

   for (genvar i = 0; i < DATA_W; i++) begin : g_term
      localparam int POS = secded_ctl_pkg::data_position(i);
      assign term[i] = data[i] ? CHK_W'(POS) : '0;
   end

   always_comb begin
      hbits = '0;
      for (int i = 0; i < DATA_W; i++) hbits ^= term[i];
   end
endmodule

// File: rtl/secded_dec.sv
module secded_dec #(
   parameter int DATA_W = 128,
   parameter int CHK_W  = 8
) (
   input  logic [DATA_W-1:0] data,
   input  logic [CHK_W:0]    st_chk,
   output logic [DATA_W-1:0] fixed,
   output logic [CHK_W-1:0]  syn,
   output logic              pmis,
   output logic              one_err,
   output logic              two_err
);
   logic [CHK_W-1:0]  recomp;
   logic [DATA_W-1:0] flip;

   secded_enc #(.DATA_W(DATA_W), .CHK_W(CHK_W)) u_recalc (
      .data  (data),
      .hbits (recomp)
   );

   assign syn  = recomp ^ st_chk[CHK_W-1:0];
   assign pmis = (^data) ^ (^st_chk);

   for (genvar i = 0; i < DATA_W; i++) begin : g_fix
      localparam int POS = secded_ctl_pkg::data_position(i);
      assign flip[i] = pmis && (syn == CHK_W'(POS));
   end

   assign fixed = data ^ flip;

   always_comb begin
      one_err = pmis && ((syn == '0) || $onehot(syn) || (|flip));
      two_err = ((syn != '0) || pmis) && !one_err;
   end
endmodule

// File: rtl/secded_word_ctl.sv
module secded_word_ctl #(
   parameter int DATA_W = 128,
   parameter int ADDR_W = 6,
   parameter int BE_W   = DATA_W / 8,
   parameter int CHK_W  = secded_ctl_pkg::hamming_bits(DATA_W)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              chk_en,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [BE_W-1:0]   wr_be,
   input  logic              rd_en,
   input  logic [ADDR_W-1:0] rd_addr,
   input  logic [2:0]        rd_class,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_waddr,
   output logic [DATA_W-1:0] mem_wdata,
   output logic [BE_W-1:0]   mem_wbe,
   output logic [CHK_W:0]    mem_wchk,
   output logic              mem_wvalid,
   output logic              mem_re,
   output logic [ADDR_W-1:0] mem_raddr,
   input  logic [DATA_W-1:0] mem_rdata,
   input  logic [CHK_W:0]    mem_rchk,
   input  logic              mem_rvalid,
   output logic              rsp_valid,
   output logic [DATA_W-1:0] rsp_data,
   output logic              err_single,
   output logic              err_double,
   output logic [CHK_W:0]    syndrome
);
   import secded_ctl_pkg::*;

   if (DATA_W % 8 != 0) begin : g_bad_width
      $error("DATA_W must be a whole number of bytes");
   end
   if (BE_W * 8 != DATA_W) begin : g_bad_be
      $error("BE_W must equal DATA_W/8");
   end
   if (CHK_W != hamming_bits(DATA_W)) begin : g_bad_chk
      $error("CHK_W does not match the Hamming bound for DATA_W");
   end

   // ---------------- write path ----------------
   logic [CHK_W-1:0] wr_hbits;
   logic             wr_full;

   secded_enc #(.DATA_W(DATA_W), .CHK_W(CHK_W)) u_wenc (
      .data  (wr_data),
      .hbits (wr_hbits)
   );

   assign wr_full    = &wr_be;
   assign mem_we     = wr_en;
   assign mem_waddr  = wr_addr;
   assign mem_wdata  = wr_data;
   assign mem_wbe    = wr_be;
   assign mem_wvalid = wr_full;
   assign mem_wchk   = wr_full ? {(^wr_data) ^ (^wr_hbits), wr_hbits} : '0;

   // ---------------- read request ----------------
   assign mem_re    = rd_en;
   assign mem_raddr = rd_addr;

   logic       pend_q;
   logic       en_q;
   req_class_e cls_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_q <= 1'b0;
         en_q   <= 1'b0;
         cls_q  <= RQ_FETCH;
      end else begin
         pend_q <= rd_en;
         if (rd_en) begin
            en_q  <= chk_en;
            cls_q <= req_class_e'(rd_class);
         end
      end
   end

   // ---------------- read response ----------------
   logic [DATA_W-1:0] fixed;
   logic [CHK_W-1:0]  syn;
   logic              pmis;
   logic              one_err;
   logic              two_err;
   logic              active;

   secded_dec #(.DATA_W(DATA_W), .CHK_W(CHK_W)) u_dec (
      .data    (mem_rdata),
      .st_chk  (mem_rchk),
      .fixed   (fixed),
      .syn     (syn),
      .pmis    (pmis),
      .one_err (one_err),
      .two_err (two_err)
   );

   assign active = pend_q && en_q && mem_rvalid;

   always_comb begin
      rsp_valid  = pend_q;
      rsp_data   = (active && cls_q != RQ_FILL) ? fixed : mem_rdata;
      err_single = active && one_err;
      err_double = active && two_err;
      syndrome   = active ? {pmis, syn} : '0;
   end
endmodule

// File: rtl/secded_word_ctl_chk.sv
module secded_word_ctl_chk #(
   parameter int DATA_W = 128,
   parameter int ADDR_W = 6,
   parameter int BE_W   = 16,
   parameter int CHK_W  = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              chk_en,
   input logic              wr_en,
   input logic [BE_W-1:0]   wr_be,
   input logic              rd_en,
   input logic [2:0]        rd_class,
   input logic [CHK_W:0]    mem_wchk,
   input logic              mem_wvalid,
   input logic [DATA_W-1:0] mem_rdata,
   input logic              mem_rvalid,
   input logic              rsp_valid,
   input logic [DATA_W-1:0] rsp_data,
   input logic              err_single,
   input logic              err_double,
   input logic [CHK_W:0]    syndrome
);
   AST_FULL_WRITE_VALID: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && (&wr_be)) |-> mem_wvalid); // R2
   AST_PARTIAL_WRITE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !(&wr_be)) |-> (!mem_wvalid && mem_wchk == '0)); // R3
   AST_DISABLED_NO_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && !chk_en) |=> (!err_single && !err_double && syndrome == '0 && rsp_data == mem_rdata)); // R4
   AST_FILL_UNCORRECTED: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && rd_class == 3'd1) |=> (rsp_data == mem_rdata)); // R5
   AST_INVALID_BYPASS: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && !mem_rvalid) |-> (!err_single && !err_double && rsp_data == mem_rdata)); // R6
   AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
      !(err_single && err_double)); // R7
   AST_RSP_NEXT_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      rd_en |=> rsp_valid); // R9
   AST_NO_SPURIOUS_RSP: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_en |=> !rsp_valid); // R9
   AST_FLAGS_ONLY_ON_RSP: assert property (@(posedge clk) disable iff (!rst_n)
      !rsp_valid |-> (!err_single && !err_double)); // R9
endmodule

bind secded_word_ctl secded_word_ctl_chk #(
   .DATA_W(DATA_W), .ADDR_W(ADDR_W), .BE_W(BE_W), .CHK_W(CHK_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .chk_en(chk_en), .wr_en(wr_en), .wr_be(wr_be),
   .rd_en(rd_en), .rd_class(rd_class), .mem_wchk(mem_wchk), .mem_wvalid(mem_wvalid),
   .mem_rdata(mem_rdata), .mem_rvalid(mem_rvalid), .rsp_valid(rsp_valid),
   .rsp_data(rsp_data), .err_single(err_single), .err_double(err_double),
   .syndrome(syndrome)
);

// File: tb/tb_secded_word_ctl.sv
`timescale 1ns/1ps
module tb_secded_word_ctl;
   localparam int DW = 128;
   localparam int AW = 6;
   localparam int BW = 16;
   localparam int CW = 8;
   localparam int DEPTH = 1 << AW;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          chk_en = 1'b1;
   logic          wr_en = 1'b0;
   logic [AW-1:0] wr_addr = '0;
   logic [DW-1:0] wr_data = '0;
   logic [BW-1:0] wr_be = '0;
   logic          rd_en = 1'b0;
   logic [AW-1:0] rd_addr = '0;
   logic [2:0]    rd_class = '0;
   logic          mem_we, mem_wvalid, mem_re;
   logic [AW-1:0] mem_waddr, mem_raddr;
   logic [DW-1:0] mem_wdata;
   logic [BW-1:0] mem_wbe;
   logic [CW:0]   mem_wchk;
   logic [DW-1:0] mem_rdata = '0;
   logic [CW:0]   mem_rchk = '0;
   logic          mem_rvalid = 1'b0;
   logic          rsp_valid, err_single, err_double;
   logic [DW-1:0] rsp_data;
   logic [CW:0]   syndrome;

   always #5 clk = ~clk;

   secded_word_ctl dut (
      .clk(clk), .rst_n(rst_n), .chk_en(chk_en), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .wr_be(wr_be), .rd_en(rd_en), .rd_addr(rd_addr),
      .rd_class(rd_class), .mem_we(mem_we), .mem_waddr(mem_waddr),
      .mem_wdata(mem_wdata), .mem_wbe(mem_wbe), .mem_wchk(mem_wchk),
      .mem_wvalid(mem_wvalid), .mem_re(mem_re), .mem_raddr(mem_raddr),
      .mem_rdata(mem_rdata), .mem_rchk(mem_rchk), .mem_rvalid(mem_rvalid),
      .rsp_valid(rsp_valid), .rsp_data(rsp_data), .err_single(err_single),
      .err_double(err_double), .syndrome(syndrome)
   );

   // external arrays modelled by the bench
   logic [DW-1:0] ram_d [DEPTH];
   logic [CW:0]   ram_c [DEPTH];
   logic          ram_v [DEPTH];

   initial begin
      for (int k = 0; k < DEPTH; k++) begin
         ram_d[k] = '0; ram_c[k] = '0; ram_v[k] = 1'b0;
      end
   end

   always @(posedge clk) begin
      if (mem_we) begin
         for (int b = 0; b < BW; b++)
            if (mem_wbe[b]) ram_d[mem_waddr][b*8 +: 8] <= mem_wdata[b*8 +: 8];
         ram_c[mem_waddr] <= mem_wchk;
         ram_v[mem_waddr] <= mem_wvalid;
      end
      if (mem_re) begin
         mem_rdata  <= ram_d[mem_raddr];
         mem_rchk   <= ram_c[mem_raddr];
         mem_rvalid <= ram_v[mem_raddr];
      end
   end

   int checks = 0;
   int errors = 0;
   int cyc = 0;
   bit done = 1'b0;

   always @(posedge clk) cyc <= cyc + 1;

   typedef struct {
      logic [DW-1:0] data;
      logic          s;
      logic          d;
      logic [CW:0]   syn;
      int            due;
      string         tag;
   } exp_t;

   exp_t sb[$];

   // position of data bit i in the codeword: i-th slot that is not a power of two
   function automatic int bit_pos(input int i);
      int p = 2;
      int seen = -1;
      while (seen < i) begin
         p++;
         if (p != 4 && p != 8 && p != 16 && p != 32 && p != 64 && p != 128) seen++;
      end
      return p;
   endfunction

   task automatic do_write(input logic [AW-1:0] a, input logic [DW-1:0] d,
                           input logic [BW-1:0] be, input string tag);
      logic full;
      full = &be;
      wr_en = 1'b1; wr_addr = a; wr_data = d; wr_be = be;
      #1;
      checks++;
      if (mem_wvalid !== full || (!full && mem_wchk !== '0) || mem_we !== 1'b1) begin
         errors++;
         $display("FAIL %s write port: valid=%0b chk=%h expected valid=%0b chk=%s",
                  tag, mem_wvalid, mem_wchk, full, full ? "any" : "0");
      end
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic do_read(input logic [AW-1:0] a, input logic [2:0] cls,
                          input logic [DW-1:0] ed, input logic es, input logic edd,
                          input logic [CW:0] esyn, input string tag);
      exp_t e;
      e.data = ed; e.s = es; e.d = edd; e.syn = esyn; e.due = cyc + 1; e.tag = tag;
      sb.push_back(e);
      rd_en = 1'b1; rd_addr = a; rd_class = cls;
      @(negedge clk);
      rd_en = 1'b0;
   endtask

   // monitor: pops expected items as responses appear
   always @(negedge clk) begin
      if (rst_n && rsp_valid) begin
         checks++;
         if (sb.size() == 0) begin
            errors++;
            $display("FAIL R9 unexpected response at cycle %0d: actual data=%h expected none",
                     cyc, rsp_data);
         end else begin
            exp_t e;
            e = sb.pop_front();
            if (rsp_data !== e.data || err_single !== e.s || err_double !== e.d ||
                syndrome !== e.syn || cyc != e.due) begin
               errors++;
               $display("FAIL %s actual data=%h s=%0b d=%0b syn=%h cyc=%0d expected data=%h s=%0b d=%0b syn=%h cyc=%0d",
                        e.tag, rsp_data, err_single, err_double, syndrome, cyc,
                        e.data, e.s, e.d, e.syn, e.due);
            end
         end
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired with %0d responses outstanding", sb.size());
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [DW-1:0] A, B, C, M;
      int p1, p2;
      A = {32'hDEADBEEF, 32'h01234567, 32'h89ABCDEF, 32'h5A5AA5A5};
      B = {32'h0F0F1234, 32'hCAFEF00D, 32'h13579BDF, 32'h2468ACE0};
      C = {32'hFFFF0000, 32'h11112222, 32'h33334444, 32'h55556666};

      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      checks++;  // R9 reset state
      if (rsp_valid !== 1'b0 || err_single !== 1'b0 || err_double !== 1'b0) begin
         errors++;
         $display("FAIL R9 reset state: rsp_valid=%0b s=%0b d=%0b expected 0 0 0",
                  rsp_valid, err_single, err_double);
      end

      // R2 full write with checking on, clean read back
      chk_en = 1'b1;
      do_write(6'd0, A, '1, "R2 full write enabled");
      do_read(6'd0, 3'd0, A, 1'b0, 1'b0, '0, "R1 clean fetch");

      // R1/R8 single data flips over several classes
      ram_d[0][5] = ~ram_d[0][5];
      do_read(6'd0, 3'd3, A, 1'b1, 1'b0, {1'b1, 8'(bit_pos(5))}, "R1 R8 dma bit5");
      ram_d[0][5] = ~ram_d[0][5];
      ram_d[0][0] = ~ram_d[0][0];
      do_read(6'd0, 3'd2, A, 1'b1, 1'b0, {1'b1, 8'(bit_pos(0))}, "R1 R8 idma bit0");
      ram_d[0][0] = ~ram_d[0][0];
      ram_d[0][127] = ~ram_d[0][127];
      do_read(6'd0, 3'd4, A, 1'b1, 1'b0, {1'b1, 8'(bit_pos(127))}, "R1 R8 victim bit127");
      ram_d[0][127] = ~ram_d[0][127];
      ram_d[0][64] = ~ram_d[0][64];
      do_read(6'd0, 3'd0, A, 1'b1, 1'b0, {1'b1, 8'(bit_pos(64))}, "R1 R8 fetch bit64");
      ram_d[0][64] = ~ram_d[0][64];

      // R1/R8 check bit 3 flip, then overall parity flip
      ram_c[0][3] = ~ram_c[0][3];
      do_read(6'd0, 3'd3, A, 1'b1, 1'b0, {1'b1, 8'd8}, "R1 R8 check bit3");
      ram_c[0][3] = ~ram_c[0][3];
      ram_c[0][8] = ~ram_c[0][8];
      do_read(6'd0, 3'd3, A, 1'b1, 1'b0, {1'b1, 8'd0}, "R1 R8 parity bit");
      ram_c[0][8] = ~ram_c[0][8];

      // R5 fill gets flags but raw data
      ram_d[0][10] = ~ram_d[0][10];
      M = A; M[10] = ~M[10];
      do_read(6'd0, 3'd1, M, 1'b1, 1'b0, {1'b1, 8'(bit_pos(10))}, "R5 fill uncorrected");
      ram_d[0][10] = ~ram_d[0][10];

      // R7 double flip
      ram_d[0][1] = ~ram_d[0][1];
      ram_d[0][2] = ~ram_d[0][2];
      M = A; M[1] = ~M[1]; M[2] = ~M[2];
      p1 = bit_pos(1); p2 = bit_pos(2);
      do_read(6'd0, 3'd3, M, 1'b0, 1'b1, {1'b0, 8'(p1 ^ p2)}, "R7 double data");
      ram_d[0][1] = ~ram_d[0][1];
      ram_d[0][2] = ~ram_d[0][2];

      // R4 checking disabled: raw data, no flags
      chk_en = 1'b0;
      ram_d[0][40] = ~ram_d[0][40];
      M = A; M[40] = ~M[40];
      do_read(6'd0, 3'd3, M, 1'b0, 1'b0, '0, "R4 disabled raw");
      ram_d[0][40] = ~ram_d[0][40];

      // R2 full write while disabled still stores protection
      do_write(6'd1, B, '1, "R2 full write disabled");
      chk_en = 1'b1;
      ram_d[1][20] = ~ram_d[1][20];
      do_read(6'd1, 3'd4, B, 1'b1, 1'b0, {1'b1, 8'(bit_pos(20))}, "R2 corrected after disabled write");
      ram_d[1][20] = ~ram_d[1][20];

      // R3 partial writes, enabled and disabled
      do_write(6'd2, C, 16'h00FF, "R3 partial enabled");
      chk_en = 1'b0;
      do_write(6'd3, C, 16'hFFFE, "R3 partial disabled");
      chk_en = 1'b1;

      // R6 invalid word bypasses checking
      ram_d[2][3] = ~ram_d[2][3];
      M = '0; M[63:0] = C[63:0]; M[3] = ~M[3];
      do_read(6'd2, 3'd3, M, 1'b0, 1'b0, '0, "R6 invalid bypass");
      M = C; M[7:0] = 8'h00;
      do_read(6'd3, 3'd0, M, 1'b0, 1'b0, '0, "R3 R6 partial word read raw");

      // R9 back-to-back requests
      do_read(6'd0, 3'd0, A, 1'b0, 1'b0, '0, "R9 back-to-back first");
      do_read(6'd1, 3'd2, B, 1'b0, 1'b0, '0, "R9 back-to-back second");

      repeat (4) @(negedge clk);
      checks++;
      if (sb.size() != 0) begin
         errors++;
         $display("FAIL R9 responses missing: actual outstanding=%0d expected 0", sb.size());
      end
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule